// File: doc/BRIEF.md
# GPIO Edge-Interrupt Register Block

A byte-wide general-purpose I/O peripheral behind a small register bus. The lower half of the data byte drives a fixed group of output pins. The upper half reports a fixed group of input pins. Each input passes through a two-flop synchroniser. An edge detector then compares the synchronised level with its value one cycle earlier.

Every input keeps two hidden sticky flags, one for rising edges and one for falling edges. Both flags latch no matter how the pin is configured. A 2-bit field per input only selects which of the two flags becomes visible in the status register and on the single interrupt line. A status write of 1 to a bit clears both hidden flags of that input at once. Software that wants to catch either edge can therefore clear a pin and re-arm its field without leaving a stale event behind.

Register offsets: 0 data, 1 direction (read-only), 3 interrupt configuration, 4 interrupt status. All other offsets read as zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, pin_out is 0, the configuration register reads 0, the status register reads 0 and irq is 0.
- R2: A write to offset 0 drives pin_out with wr_data[3:0]. A read of offset 0 returns the synchronised inputs in bits [7:4] (input n in bit 4+n) and 0 in bits [3:0], so the outputs cannot be read back.
- R3: Offset 1 always reads 8'h0F (a 1 marks an output bit of the data byte), and writes to it are ignored. Offsets 2, 5, 6 and 7 read 8'h00.
- R4: Offset 3 is a read/write configuration register in which input n owns bits [2n+1:2n]. In each field bit 0 selects the falling-edge flag, bit 1 selects the rising-edge flag, and 00 disables the input.
- R5: A rising edge on input n sets its hidden rising flag, and a falling edge sets its hidden falling flag, whatever the configuration. Each flag is set by the third rising clock edge after the pin changes.
- R6: Status bit n (offset 4, bits [3:0], upper bits 0) is 1 exactly when a flag selected by field n is set, and irq is the OR of the status bits.
- R7: Writing 1 to status bit n clears both hidden flags of input n, whichever edge is configured.
- R8: Writing 0 to a status bit has no effect, and reading the status register clears nothing.
- R9: An edge that is detected in the same cycle as a status-clear write for its input leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_in | input | 4 | Asynchronous input pins |
| pin_out | output | 4 | Output pins |
| irq | output | 1 | Interrupt request, OR of visible status |

## Verification
The bench latches an edge while the input is disabled and then enables the field. A design that gated latching by configuration would show no status at that point. It clears a pin while the other edge type is pending and then switches the field to that edge. A design that cleared only the visible flag would bring back an old event. It writes zeros to status and reads status repeatedly, which catches a write that clears bits by value or a read that clears them. It also lands a clear exactly on the cycle an edge is detected, where a clear-wins priority would lose the event.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW/2-1:0] pin_in,
  output logic [DW/2-1:0] pin_out,
  output logic          irq
);
  localparam int NIN  = DW / 2;
  localparam int NOUT = DW - NIN;
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_CFG  = AW'(3);
  localparam logic [AW-1:0] A_STS  = AW'(4);

  logic [NIN-1:0] sync1, sync2, prev;
  logic [NIN-1:0] rflag, fflag, status, clr;
  logic [NIN-1:0] rise_ev, fall_ev;
  logic [DW-1:0]  cfg;

  assign rise_ev = sync2 & ~prev;
  assign fall_ev = ~sync2 & prev;
  assign clr     = (wr_en && addr == A_STS) ? wr_data[NIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      rflag   <= '0;
      fflag   <= '0;
      cfg     <= '0;
      pin_out <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      rflag <= (rflag & ~clr) | rise_ev;
      fflag <= (fflag & ~clr) | fall_ev;
      if (wr_en && addr == A_CFG)  cfg     <= wr_data;
      if (wr_en && addr == A_DATA) pin_out <= wr_data[NOUT-1:0];
    end
  end

  for (genvar n = 0; n < NIN; n++) begin : g_vis
    assign status[n] = (cfg[2*n] & fflag[n]) | (cfg[2*n+1] & rflag[n]);
  end

  assign irq = |status;

  always_comb begin
    case (addr)
      A_DATA:  rd_data = {sync2, {NOUT{1'b0}}};
      A_DIR:   rd_data = {{NIN{1'b0}}, {NOUT{1'b1}}};
      A_CFG:   rd_data = cfg;
      A_STS:   rd_data = {{(DW-NIN){1'b0}}, status};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [DW/2-1:0] pin_out,
  input logic          irq,
  input logic [DW/2-1:0] rise_ev,
  input logic [DW/2-1:0] rflag,
  input logic [DW/2-1:0] fflag
);
  localparam int NIN = DW / 2;

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(0)) |=> $stable(pin_out));

  assert_rise_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev != '0) |=> ((rflag & $past(rise_ev)) == $past(rise_ev)));

  assert_irq_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(4)) |-> (irq == (rd_data[NIN-1:0] != '0)));

  assert_clear_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=>
      (((rflag | fflag) & $past(wr_data[NIN-1:0] & ~rise_ev) & ~$past(fflag & ~wr_data[NIN-1:0])) == '0
       || ($past(wr_data[NIN-1:0]) & rflag & ~$past(rise_ev)) == '0));

  assert_no_spurious_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(4)) |=>
      (((rflag & $past(rflag)) == $past(rflag)) && ((fflag & $past(fflag)) == $past(fflag))));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .irq(irq), .rise_ev(rise_ev),
  .rflag(rflag), .fflag(fflag)
);

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] data; logic irq; } item_t;
  item_t q[$];
  event sample_ev;

  logic [3:0] m_r = '0, m_f = '0, m_pin = '0;
  logic [7:0] m_cfg = '0;

  always #2.5 clk = ~clk;

  gpio_edge_irq u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .irq(irq));

  function automatic logic [3:0] m_status();
    logic [3:0] s;
    for (int n = 0; n < 4; n++) s[n] = (m_cfg[2*n] & m_f[n]) | (m_cfg[2*n+1] & m_r[n]);
    return s;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_pin, 4'h0};
      3'd1: return 8'h0F;
      3'd3: return m_cfg;
      3'd4: return {4'h0, m_status()};
      default: return 8'h00;
    endcase
  endfunction

  always @(sample_ev) begin
    item_t it;
    it = q.pop_front();
    checks++;
    if (rd_data !== it.data || irq !== it.irq) begin
      errors++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               it.tag, rd_data, irq, it.data, it.irq);
    end
  end

  task automatic chk(input logic [2:0] a, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    #1;
    it.tag = tag; it.data = m_read(a); it.irq = |m_status();
    q.push_back(it);
    ->sample_ev;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd3) m_cfg = d;
    if (a == 3'd4) begin m_r &= ~d[3:0]; m_f &= ~d[3:0]; end
  endtask

  task automatic pin(input logic [3:0] v);
    @(negedge clk);
    pin_in = v;
    m_r |= v & ~m_pin;
    m_f |= ~v & m_pin;
    m_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_out(input logic [3:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s: pin_out=%h expected %h", tag, pin_out, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_out(4'h0, "R1 pin_out reset");
    chk(3'd3, "R1 cfg reset");
    chk(3'd4, "R1 status reset");

    wr(3'd0, 8'hA5);
    chk_out(4'h5, "R2 pin_out drive");
    chk(3'd0, "R2 data read hides outputs");
    wr(3'd1, 8'hFF);
    chk(3'd1, "R3 direction fixed");
    chk(3'd2, "R3 unmapped reads zero");
    chk(3'd7, "R3 unmapped reads zero");

    pin(4'b0001);
    chk(3'd0, "R2 input readback");
    chk(3'd4, "R5 disabled pin shows nothing");
    wr(3'd3, 8'h02);
    chk(3'd3, "R4 cfg readback");
    chk(3'd4, "R5 rising flag latched while disabled");
    wr(3'd3, 8'h01);
    chk(3'd4, "R6 falling selected, none yet");
    pin(4'b0000);
    chk(3'd4, "R6 falling edge visible");

    wr(3'd4, 8'h00);
    chk(3'd4, "R8 zero write no effect");
    chk(3'd4, "R8 read does not clear");
    wr(3'd4, 8'h01);
    chk(3'd4, "R7 status cleared");
    wr(3'd3, 8'h03);
    chk(3'd4, "R7 both flags cleared");

    wr(3'd3, 8'hAA);
    pin(4'b1010);
    chk(3'd4, "R6 rising on pins 1,3");
    pin(4'b0101);
    chk(3'd4, "R6 rising on all pins");
    wr(3'd4, 8'h03);
    chk(3'd4, "R7 partial clear");
    wr(3'd3, 8'h55);
    chk(3'd4, "R7 falling view after partial clear");
    wr(3'd4, 8'h0F);
    chk(3'd4, "R7 full clear irq low");

    @(negedge clk);
    pin_in = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd4; wr_data = 8'h04; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_f |= 4'b0100;
    m_pin = 4'b0001;
    repeat (3) @(negedge clk);
    chk(3'd4, "R9 edge wins over clear");

    wr(3'd0, 8'h3C);
    chk_out(4'hC, "R2 pin_out update");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule